// File: doc/BRIEF.md
# Nibble-Serial Clock-Chip Register Master

This block drives a three-wire serial link to a timekeeping chip whose registers are four bits wide. The wires are a chip enable, a serial clock and a single data line. The block supplies a separate output-enable for the data line, so one pin can carry both directions. A host sets chip enable, then raises a one-cycle request carrying a 4-bit register address, a read/write flag and, for writes, a 4-bit value. The block then runs one complete 16-bit frame on the serial wires.

Every frame begins with a command nibble and the register address. A read then releases the data line. Four dummy bits arrive and are thrown away, and the next four bits arrive as the register contents. A write keeps driving the line. It sends a second command nibble that marks the data phase, then the value. When the frame ends the block pulses `done` for one cycle, and after a read it presents the received nibble on `rd_data`. The serial clock runs at the system clock divided by twice `HALF_CYC`.

Top module: `nibble_rtc_master`

## Requirements
- R1: After reset, `ser_clk`, `ser_oe`, `ser_dout` and `done` are 0, and `rd_data` is 0.
- R2: A request is taken only when no frame is in progress and `host_ce` is 1. A request made while `host_ce` is 0 produces no serial clock and no `done`. A request made during a frame does not alter that frame and does not start a further frame.
- R3: The first eight bits of every frame are driven in this order: 1, the direction bit (1 = read, 0 = write), 1, 0, then the address MSB first.
- R4: In a read, `ser_oe` is 0 from the ninth bit through the sixteenth. The bits sampled at the 9th–12th rising edges are discarded. The bits sampled at the 13th–16th rising edges become `rd_data[3:0]`, MSB first.
- R5: In a write, bits 9–16 are 1, 0, 0, 1 followed by the write value MSB first. `ser_oe` is 1 for all sixteen bits.
- R6: `ser_clk` is low while idle. Each low phase and each high phase lasts `HALF_CYC` system cycles. `ser_dout` changes only while `ser_clk` is low, and input is sampled at rising edges.
- R7: `done` is high for exactly one cycle, right after the sixteenth falling edge of `ser_clk`. `rd_data` changes only when a read completes; writes and aborted frames leave it unchanged.
- R8: If `host_ce` falls during a frame, the frame is abandoned on the next cycle. `ser_clk` and `ser_oe` go to 0, no `done` is given, and the block can accept a new request.
- R9: `ser_ce` follows `host_ce` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ce | input | 1 | Chip enable requested by the host |
| req | input | 1 | One-cycle access request |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Value to write |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 4 | Last nibble read |
| ser_ce | output | 1 | Chip enable to the clock chip |
| ser_clk | output | 1 | Serial clock |
| ser_dout | output | 1 | Serial data out |
| ser_oe | output | 1 | Data line output enable |
| ser_din | input | 1 | Serial data in |

## Verification
During the dummy bits the bench's model chip drives the inverse of the real value. A design that keeps the wrong four bits, or is off by one bit position, therefore returns a visibly wrong nibble. Every bit and its output-enable are recorded at each rising edge. A design that turns the line around too early or too late, or never turns it around on a read, fails the direction checks. A master that ignores `host_ce`, accepts a second request during a frame, or keeps clocking after chip enable drops would show extra clock edges or a stray `done`. A write that corrupts `rd_data` is caught because `rd_data` is read back after writes and after aborts.

// File: rtl/nibble_rtc_master.sv
module nibble_rtc_master #(
  parameter int HALF_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_ce,
  input  logic       req,
  input  logic       req_rd,
  input  logic [3:0] req_addr,
  input  logic [3:0] req_wdata,
  output logic       done,
  output logic [3:0] rd_data,
  output logic       ser_ce,
  output logic       ser_clk,
  output logic       ser_dout,
  output logic       ser_oe,
  input  logic       ser_din
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF_CYC - 1);
  localparam logic [3:0] LAST_BIT = 4'd15;
  localparam logic [3:0] TURN_BIT = 4'd8;
  localparam logic [3:0] KEEP_BIT = 4'd12;

  logic          busy;
  logic          dir_rd;
  logic [CW-1:0] div_cnt;
  logic [3:0]    bit_idx;
  logic [15:0]   shreg;
  logic [3:0]    rx;

  wire tick  = (div_cnt == DIV_LAST);
  wire start = !busy && req && host_ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      dir_rd  <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      rx      <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      ser_clk <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        dir_rd  <= req_rd;
        div_cnt <= '0;
        bit_idx <= '0;
        ser_clk <= 1'b0;
        shreg   <= req_rd ? {4'b1110, req_addr, 8'h00}
                          : {4'b1010, req_addr, 4'b1001, req_wdata};
      end else if (busy) begin
        if (!host_ce) begin
          busy    <= 1'b0;
          ser_clk <= 1'b0;
          div_cnt <= '0;
        end else if (tick) begin
          div_cnt <= '0;
          if (!ser_clk) begin
            ser_clk <= 1'b1;
            if (dir_rd && bit_idx >= KEEP_BIT)
              rx <= {rx[2:0], ser_din};
          end else begin
            ser_clk <= 1'b0;
            if (bit_idx == LAST_BIT) begin
              busy <= 1'b0;
              done <= 1'b1;
              if (dir_rd) rd_data <= rx;
            end else begin
              bit_idx <= bit_idx + 4'd1;
              shreg   <= {shreg[14:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + CW'(1);
        end
      end
    end
  end

  assign ser_ce   = host_ce;
  assign ser_dout = busy & shreg[15];
  assign ser_oe   = busy & !(dir_rd && bit_idx >= TURN_BIT);

endmodule

// File: rtl/nibble_rtc_master_chk.sv
module nibble_rtc_master_chk (
  input logic clk,
  input logic rst_n,
  input logic host_ce,
  input logic req,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_dout,
  input logic ser_oe
);
  a_r1_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_oe));

  a_r2_no_start_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && !host_ce) |=> !busy);

  a_r6_dout_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(ser_clk) && !ser_clk));

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !host_ce) |=> (!ser_clk && !ser_oe && !done));
endmodule

bind nibble_rtc_master nibble_rtc_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .req(req), .busy(busy),
  .done(done), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_oe(ser_oe)
);

// File: tb/nibble_rtc_master_tb_top.sv
module nibble_rtc_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 0, rst_n = 0, host_ce = 0, req = 0, req_rd = 0, ser_din = 0;
  logic [3:0] req_addr = 0, req_wdata = 0;
  logic done, ser_ce, ser_clk, ser_dout, ser_oe;
  logic [3:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  nibble_rtc_master #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .req(req), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_oe(ser_oe),
    .ser_din(ser_din));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic frame(input bit rd, input logic [3:0] addr, input logic [3:0] wd,
                       input logic [3:0] nib, output logic [15:0] bits,
                       output logic [15:0] oes, output int ndone, output time tper);
    time t0;
    ndone = 0; tper = 0; t0 = 0;
    fork
      begin
        @(negedge clk);
        req = 1; req_rd = rd; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req = 0;
      end
      begin
        for (int k = 0; k < 16; k++) begin
          @(posedge ser_clk);
          if (k == 0) t0 = $time;
          if (k == 1) tper = $time - t0;
          bits[15-k] = ser_dout;
          oes[15-k] = ser_oe;
          @(negedge ser_clk);
          if (k + 1 >= 8 && k + 1 < 12) ser_din = ~nib[11-(k+1)];
          else if (k + 1 >= 12) ser_din = nib[15-(k+1)];
        end
      end
    join
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) ndone++;
    end
  endtask

  task automatic t_reset;
    check(ser_clk == 0 && ser_oe == 0 && ser_dout == 0, "R1 idle pins", {ser_clk, ser_oe, ser_dout}, 0);
    check(done == 0, "R1 done", done, 0);
    check(rd_data == 0, "R1 rd_data", rd_data, 0);
    check(ser_ce == host_ce, "R9 ce follow low", ser_ce, host_ce);
  endtask

  task automatic t_read(input logic [3:0] addr, input logic [3:0] nib);
    logic [15:0] b, o; int nd; time tp;
    frame(1, addr, 4'h0, nib, b, o, nd, tp);
    check(b[15:8] == {4'b1110, addr}, "R3 read header", b[15:8], {4'b1110, addr});
    check(o == 16'hFF00, "R4 read direction", o, 16'hFF00);
    check(rd_data == nib, "R4 read value", rd_data, nib);
    check(nd == 1, "R7 single done", nd, 1);
    check(tp == 2*HALF*CLK_PERIOD, "R6 clock period", int'(tp), 2*HALF*CLK_PERIOD);
  endtask

  task automatic t_write(input logic [3:0] addr, input logic [3:0] wd);
    logic [15:0] b, o; int nd; time tp; logic [3:0] prev;
    prev = rd_data;
    frame(0, addr, wd, 4'h0, b, o, nd, tp);
    check(b == {4'b1010, addr, 4'b1001, wd}, "R5 write frame", b, {4'b1010, addr, 4'b1001, wd});
    check(o == 16'hFFFF, "R5 write drives", o, 16'hFFFF);
    check(nd == 1, "R7 write done", nd, 1);
    check(rd_data == prev, "R7 rd_data held", rd_data, prev);
  endtask

  task automatic t_no_ce;
    int edges = 0, nd = 0;
    host_ce = 0;
    @(negedge clk);
    check(ser_ce == 0, "R9 ce low", ser_ce, 0);
    req = 1; req_rd = 1; req_addr = 4'h3;
    @(negedge clk); req = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ser_clk) edges++;
      if (done) nd++;
    end
    check(edges == 0 && nd == 0, "R2 no ce ignored", edges + nd, 0);
    host_ce = 1;
    @(negedge clk);
    check(ser_ce == 1, "R9 ce high", ser_ce, 1);
  endtask

  task automatic t_busy_req;
    logic [15:0] b, o; int nd, edges; time tp;
    edges = 0;
    fork
      frame(1, 4'h6, 4'h0, 4'hC, b, o, nd, tp);
      begin
        repeat (12) @(negedge clk);
        req = 1; req_rd = 0; req_addr = 4'h9; req_wdata = 4'h1;
        @(negedge clk); req = 0;
      end
    join
    check(b[15:8] == 8'hE6 && rd_data == 4'hC, "R2 busy req ignored", {b[15:8], rd_data}, 12'hE6C);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ser_clk) edges++;
    end
    check(edges == 0, "R2 no second frame", edges, 0);
  endtask

  task automatic t_abort;
    int nd = 0;
    logic [3:0] prev;
    prev = rd_data;
    @(negedge clk);
    req = 1; req_rd = 1; req_addr = 4'hA;
    @(negedge clk); req = 0;
    repeat (20) @(negedge clk);
    host_ce = 0;
    @(negedge clk);
    @(negedge clk);
    check(ser_clk == 0 && ser_oe == 0, "R8 abort quiet", {ser_clk, ser_oe}, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) nd++;
    end
    check(nd == 0, "R8 no done on abort", nd, 0);
    check(rd_data == prev, "R8 rd_data kept", rd_data, prev);
    host_ce = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    host_ce = 1;
    @(negedge clk);
    t_read(4'hD, 4'h9);
    t_read(4'h2, 4'h6);
    t_write(4'h5, 4'hB);
    t_write(4'hF, 4'h0);
    t_no_ce();
    t_busy_req();
    t_abort();
    t_read(4'h8, 4'h3);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule